// File: doc/BRIEF.md
# Interval Timer with Selectable Tick Source

This block is an 8-bit interval timer for a microcontroller peripheral set. Software writes a reference value and a control word. A source multiplexer picks the tick that advances the counter. The tick can come from one of four taps of a free-running system-clock divider (/512, /256, /64, /8), from the undivided clock, from a slow subclock input, or from an external clock pin. While the timer runs, each tick adds one to the counter. A tick that finds the counter equal to the reference is a match. A match sends the counter back to zero, sets a sticky pending flag and toggles a match output pin. The interrupt request is the pending flag gated by an interrupt enable.

The run control is a two-state machine. In state HALT the counter is frozen. In state COUNT it advances on ticks. A control write with the enable bit set takes HALT to COUNT (transition START). A control write with the enable bit clear takes COUNT to HALT (transition STOP). Any other write keeps the current state. Two control bits act as one-shot commands: one clears the counter and one clears the pending flag. A build parameter gives a reduced variant whose mux offers neither the undivided clock nor the external pin.

Top module: `interval_timer`

## Requirements
- R1: After reset the count reads 0, the reference reads 0xFF, the control word reads 0, and both match_out and irq are 0.
- R2: The 3-bit select field at control bits 3:1 picks the tick. Code 0 gives one tick every 512 cycles, code 1 every 256, code 2 every 64, code 3 every 8 and code 4 every cycle. Code 5 gives one tick per subclock rising edge, code 6 one tick per external-clock rising edge, and code 7 gives no ticks.
- R3: In COUNT, a tick adds one to the count. A tick that finds the count equal to the reference is a match and sets the count to 0, so matches repeat every reference+1 ticks.
- R4: match_out toggles on every match.
- R5: A match sets the pending flag. The flag stays set until a control write with bit 6 set clears it. If a match and that clear happen in the same cycle, the flag ends up set.
- R6: irq is high exactly when the pending flag and the interrupt enable (control bit 5) are both 1.
- R7: A control write with bit 4 set makes the count 0 on the next cycle. This takes priority over a tick in the same cycle.
- R8: Control read-back places run state at bit 0, select at bits 3:1, interrupt enable at bit 5 and the pending flag at bit 7. Bits 4 and 6 always read 0. A write to bit 7 is ignored.
- R9: Control bit 0 written as 1 enters COUNT and written as 0 enters HALT. In HALT the count holds and the pending flag is kept.
- R10: The subclock and external clock each pass through a two-flop synchronizer and a rising-edge detector. Each rising edge gives exactly one tick, and the count changes on the third clock edge after the input rises.
- R11: With FULL_SRC = 0, codes 4 and 6 give no ticks. All other codes behave as in R2.
- R12: Writes go to the control word at wr_addr 0 and to the reference at wr_addr 1. Reads return control at rd_addr 0, reference at 1, count at 2, and 0 at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_clk | input | 1 | Slow subclock, asynchronous |
| ext_clk | input | 1 | External clock pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 reference |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | CNT_W | Read data, combinational |
| irq | output | 1 | Interrupt request |
| match_out | output | 1 | Match output pin, toggles per match |

## Verification
Assertions run on every cycle and check the local rules. A non-matching tick adds exactly one. A match always returns the count to zero and flips the output pin. Without a match or a clear, the pending flag keeps its value. In HALT the count stays still. An edge detector never fires twice in a row. irq never rises without the enable. Other behaviour shows only in the bench scenarios: the real match period for each divider tap, the three-edge latency of the synchronized inputs, the same-cycle priority of a set over a pending clear, and the missing sources in the reduced variant. The bench checks these against a behavioural model compared every cycle and against hand-computed intervals.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [2:0] {
        SRC_DIV512 = 3'd0,
        SRC_DIV256 = 3'd1,
        SRC_DIV64  = 3'd2,
        SRC_DIV8   = 3'd3,
        SRC_DIV1   = 3'd4,
        SRC_SUB    = 3'd5,
        SRC_EXT    = 3'd6,
        SRC_NONE   = 3'd7
    } src_sel_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_SEL_LSB  = 1;
    localparam int CTL_SEL_W    = 3;
    localparam int CTL_CLR_BIT  = 4;
    localparam int CTL_IE_BIT   = 5;
    localparam int CTL_PCLR_BIT = 6;
    localparam int CTL_PEND_BIT = 7;

    localparam logic       WA_CTRL  = 1'b0;
    localparam logic       WA_REF   = 1'b1;
    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_REF   = 2'd1;
    localparam logic [1:0] RA_COUNT = 2'd2;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], async_in};
    end

    assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("edge detector fired twice in a row"); // R10
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import timer_pkg::*;
#(
    parameter int DIV_LOG  = 9,
    parameter bit FULL_SRC = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sub_clk,
    input  logic     ext_clk,
    input  src_sel_e sel,
    output logic     tick
);
    localparam int TAP_A = DIV_LOG;
    localparam int TAP_B = DIV_LOG - 1;
    localparam int TAP_C = DIV_LOG - 3;
    localparam int TAP_D = DIV_LOG - 6;

    logic [DIV_LOG-1:0] div_q;
    logic t_a, t_b, t_c, t_d;
    logic sub_rise, ext_rise;
    logic fast_tick, pin_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign t_a = &div_q[TAP_A-1:0];
    assign t_b = &div_q[TAP_B-1:0];
    assign t_c = &div_q[TAP_C-1:0];
    assign t_d = &div_q[TAP_D-1:0];

    tmr_edge_sync #(.SYNC_STAGES(2)) u_sub_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sub_clk), .rise(sub_rise)
    );
    tmr_edge_sync #(.SYNC_STAGES(2)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
    );

    generate
        if (FULL_SRC) begin : g_full
            assign fast_tick = 1'b1;
            assign pin_tick  = ext_rise;
        end else begin : g_lite
            assign fast_tick = 1'b0;
            assign pin_tick  = 1'b0;
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        unique case (sel)
            SRC_DIV512: tick = t_a;
            SRC_DIV256: tick = t_b;
            SRC_DIV64:  tick = t_c;
            SRC_DIV8:   tick = t_d;
            SRC_DIV1:   tick = fast_tick;
            SRC_SUB:    tick = sub_rise;
            SRC_EXT:    tick = pin_tick;
            SRC_NONE:   tick = 1'b0;
            default:    tick = 1'b0;
        endcase
    end

    AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_NONE) |-> !tick) else $error("tick on empty source"); // R2
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             en_bit,
    input  logic             clr_stb,
    input  logic             pclr_stb,
    input  logic             tick,
    input  logic [CNT_W-1:0] ref_val,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic             tout
);
    run_state_e state_q, state_d;
    logic       match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_wr && en_bit)  state_d = ST_COUNT;
            ST_COUNT: if (ctrl_wr && !en_bit) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    always_comb begin
        running = (state_q == ST_COUNT);
        match   = running && tick && (cnt == ref_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
            tout <= 1'b0;
        end else begin
            if (clr_stb || match)    cnt <= '0;
            else if (running && tick) cnt <= cnt + 1'b1;
            if (match)               pend <= 1'b1;
            else if (pclr_stb)       pend <= 1'b0;
            if (match)               tout <= ~tout;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !clr_stb && cnt != ref_val) |=> cnt == $past(cnt) + 1'b1)
        else $error("count did not step"); // R3
    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cnt == '0) else $error("count not zero after match"); // R3
    AST_PIN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> tout != $past(tout)) else $error("pin did not toggle"); // R4
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !pclr_stb) |=> pend == $past(pend)) else $error("pending changed"); // R5
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr_stb) |=> $stable(cnt)) else $error("count moved in halt"); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DIV_LOG  = 9,
    parameter bit FULL_SRC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_clk,
    input  logic             ext_clk,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             match_out
);
    localparam logic [CNT_W-1:0] REF_RST = '1;

    src_sel_e         sel_q;
    logic             ie_q;
    logic [CNT_W-1:0] ref_q;
    logic             ctrl_wr, ref_wr;
    logic             tick, running, pend;
    logic [CNT_W-1:0] cnt;

    assign ctrl_wr = wr_en && (wr_addr == WA_CTRL);
    assign ref_wr  = wr_en && (wr_addr == WA_REF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SRC_DIV512;
            ie_q  <= 1'b0;
            ref_q <= REF_RST;
        end else begin
            if (ctrl_wr) begin
                sel_q <= src_sel_e'(wr_data[CTL_SEL_LSB +: CTL_SEL_W]);
                ie_q  <= wr_data[CTL_IE_BIT];
            end
            if (ref_wr) ref_q <= wr_data;
        end
    end

    tmr_prescaler #(.DIV_LOG(DIV_LOG), .FULL_SRC(FULL_SRC)) u_presc (
        .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk), .ext_clk(ext_clk),
        .sel(sel_q), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr),
        .en_bit(wr_data[CTL_EN_BIT]),
        .clr_stb(ctrl_wr && wr_data[CTL_CLR_BIT]),
        .pclr_stb(ctrl_wr && wr_data[CTL_PCLR_BIT]),
        .tick(tick), .ref_val(ref_q),
        .running(running), .cnt(cnt), .pend(pend), .tout(match_out)
    );

    assign irq = pend && ie_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_CTRL: begin
                rd_data[CTL_EN_BIT]                      = running;
                rd_data[CTL_SEL_LSB +: CTL_SEL_W]        = sel_q;
                rd_data[CTL_IE_BIT]                      = ie_q;
                rd_data[CTL_PEND_BIT]                    = pend;
            end
            RA_REF:   rd_data = ref_q;
            RA_COUNT: rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q) else $error("irq without enable"); // R6
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_clk = 1'b0, ext_clk = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data, l_rd_data;
    logic       irq, match_out, l_irq, l_match;

    always #5 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .match_out(match_out)
    );
    interval_timer #(.FULL_SRC(1'b0)) u_interval_timer_lite (
        .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(l_rd_data), .irq(l_irq), .match_out(l_match)
    );

    int  vectors = 0, fails = 0, cycles = 0;
    bit  model_on = 0, done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int         m_div;
    logic [2:0] m_sel;
    bit         m_en, m_ie, m_pend, m_tout, tk, hit;
    logic [7:0] m_cnt, m_ref, exp_rd;
    bit         e_h[3], s_h[3];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_div = 0; m_sel = 0; m_en = 0; m_ie = 0; m_pend = 0; m_tout = 0;
            m_cnt = 0; m_ref = 8'hFF;
            foreach (e_h[i]) begin e_h[i] = 0; s_h[i] = 0; end
        end else begin
            case (m_sel)
                3'd0: tk = (m_div % 512) == 511;
                3'd1: tk = (m_div % 256) == 255;
                3'd2: tk = (m_div % 64) == 63;
                3'd3: tk = (m_div % 8) == 7;
                3'd4: tk = 1;
                3'd5: tk = s_h[1] && !s_h[2];
                3'd6: tk = e_h[1] && !e_h[2];
                default: tk = 0;
            endcase
            hit = m_en && tk && (m_cnt == m_ref);
            if (wr_en && !wr_addr && wr_data[4]) m_cnt = 0;
            else if (hit) m_cnt = 0;
            else if (m_en && tk) m_cnt = m_cnt + 8'd1;
            if (hit) m_pend = 1;
            else if (wr_en && !wr_addr && wr_data[6]) m_pend = 0;
            if (hit) m_tout = !m_tout;
            if (wr_en && !wr_addr) begin
                m_en = wr_data[0]; m_sel = wr_data[3:1]; m_ie = wr_data[5];
            end
            if (wr_en && wr_addr) m_ref = wr_data;
            m_div = (m_div + 1) % 512;
            e_h[2] = e_h[1]; e_h[1] = e_h[0]; e_h[0] = ext_clk;
            s_h[2] = s_h[1]; s_h[1] = s_h[0]; s_h[0] = sub_clk;
        end
        #2;
        if (model_on && !done) begin
            case (rd_addr)
                2'd0: exp_rd = {m_pend, 1'b0, m_ie, 1'b0, m_sel, m_en};
                2'd1: exp_rd = m_ref;
                2'd2: exp_rd = m_cnt;
                default: exp_rd = 8'h00;
            endcase
            check("R4 model match_out", match_out, m_tout);
            check("R6 model irq", irq, m_pend && m_ie);
            check("R12 model rd_data", rd_data, exp_rd);
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [7:0] cw(bit en, logic [2:0] sel, bit clr, bit ie, bit pc);
        return {1'b0, pc, ie, clr, sel, en};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; #1 v = rd_data;
    endtask

    task automatic interval(output int n);
        logic last;
        int   guard;
        @(negedge clk); last = match_out; guard = 0;
        while (match_out == last && guard < 2000) begin @(negedge clk); guard++; end
        last = match_out; n = 0;
        do begin @(negedge clk); n++; end while (match_out == last && n < 2000);
    endtask

    task automatic pulse_ext(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); ext_clk = 1; repeat (2) @(negedge clk);
            ext_clk = 0; repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse_sub(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); sub_clk = 1; repeat (2) @(negedge clk);
            sub_clk = 0; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] v, a, b;
        int n, tg;
        logic lm;
        repeat (3) @(negedge clk);
        rst_n = 1; model_on = 1;

        // R1 reset state, R12 address map
        rd(2'd0, v); check("R1 ctrl reset", v, 8'h00);
        rd(2'd1, v); check("R1 ref reset", v, 8'hFF);
        rd(2'd2, v); check("R1 count reset", v, 8'h00);
        check("R1 match_out reset", match_out, 0);
        check("R1 irq reset", irq, 0);
        rd(2'd3, v); check("R12 unused addr", v, 8'h00);

        // R3 interval ref+1 at divide-by-1
        wr(1'b1, 8'h10);
        wr(1'b0, cw(1, 3'd4, 1, 1, 0));
        interval(n); check("R3 period ref 0x10 /1", n, 17);
        check("R6 irq with enable", irq, 1);
        rd(2'd0, v); check("R8 strobes read 0", v & 8'h50, 8'h00);
        check("R8 ctrl layout", v & 8'hAF, 8'hA9);
        rd(2'd2, v); check("R11 lite no /1 tick", l_rd_data, 8'h00);

        // R9 halt freezes, R5 pending clear
        wr(1'b0, cw(0, 3'd4, 0, 1, 0));
        rd(2'd0, v); check("R9 pending kept in halt", v[7], 1);
        rd(2'd2, a); repeat (20) @(negedge clk);
        rd(2'd2, b); check("R9 count frozen", b, a);
        wr(1'b0, cw(0, 3'd4, 0, 1, 1));
        rd(2'd0, v); check("R5 pending cleared", v[7], 0);
        check("R6 irq low after clear", irq, 0);

        // R6 enable gating, R5 set wins over clear
        wr(1'b1, 8'h00);
        wr(1'b0, cw(1, 3'd4, 1, 0, 0));
        repeat (5) @(negedge clk);
        rd(2'd0, v); check("R6 pending set", v[7], 1);
        check("R6 irq masked", irq, 0);
        wr(1'b0, cw(1, 3'd4, 0, 0, 1));
        rd(2'd0, v); check("R5 set beats clear", v[7], 1);
        wr(1'b0, cw(1, 3'd4, 0, 0, 0) | 8'h80);
        rd(2'd0, v); check("R8 bit7 write ignored", v & 8'h0F, 8'h09);

        // R7 counter clear while running
        wr(1'b1, 8'hFF);
        wr(1'b0, cw(1, 3'd4, 1, 0, 1));
        repeat (40) @(negedge clk);
        rd_addr = 2'd2;
        wr(1'b0, cw(1, 3'd4, 1, 0, 0));
        #1 check("R7 clear beats tick", rd_data, 8'h00);

        // R2 divider taps
        wr(1'b1, 8'h00);
        wr(1'b0, cw(1, 3'd0, 1, 0, 0)); interval(n); check("R2 /512", n, 512);
        wr(1'b0, cw(1, 3'd1, 1, 0, 0)); interval(n); check("R2 /256", n, 256);
        wr(1'b0, cw(1, 3'd2, 1, 0, 0)); interval(n); check("R2 /64", n, 64);
        wr(1'b1, 8'h01);
        wr(1'b0, cw(1, 3'd3, 1, 0, 0)); interval(n); check("R2 /8 ref 1", n, 16);
        tg = 0; @(negedge clk); lm = l_match;
        for (int i = 0; i < 130; i++) begin
            @(negedge clk); if (l_match != lm) tg++; lm = l_match;
        end
        check("R11 lite /8 still ticks", tg >= 7, 1);

        // R2 reserved code
        wr(1'b0, cw(1, 3'd7, 1, 0, 0));
        repeat (30) @(negedge clk);
        rd(2'd2, v); check("R2 code 7 no tick", v, 8'h00);

        // R10 external clock latency and count
        wr(1'b1, 8'hFF);
        wr(1'b0, cw(1, 3'd6, 1, 0, 0));
        repeat (3) @(negedge clk);
        rd_addr = 2'd2;
        @(negedge clk); ext_clk = 1;
        @(negedge clk); #1 check("R10 edge+1 unchanged", rd_data, 8'h00);
        @(negedge clk); #1 check("R10 edge+2 unchanged", rd_data, 8'h00);
        @(negedge clk); #1 check("R10 edge+3 counted", rd_data, 8'h01);
        ext_clk = 0; repeat (2) @(negedge clk);
        pulse_ext(2); repeat (4) @(negedge clk);
        rd(2'd2, v); check("R10 ext edges", v, 8'h03);
        check("R11 lite no ext tick", l_rd_data, 8'h00);

        // R10 subclock
        wr(1'b0, cw(1, 3'd5, 1, 0, 0));
        pulse_sub(2); repeat (4) @(negedge clk);
        rd(2'd2, v); check("R10 sub edges", v, 8'h02);
        check("R11 lite sub ticks", l_rd_data, 8'h02);

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule